// File: doc/BRIEF.md
# CPU Doze and Idle Controller

This block sets how often a processor core may execute an instruction cycle. Peripheral logic runs on every cycle. A single control register chooses between three things: full speed, a doze mode, and what a sleep request does. In doze mode the core is enabled for one cycle out of every N. N is a power of two chosen by a 3-bit code. Each cycle the block drives two enables: `cpuEn`, which gates the core's instruction cycle, and `periphEn`, which gates the peripheral clock domain.

Interrupt entry and interrupt return arrive as single-cycle strobes. Two policy bits in the register let hardware change the doze enable on these events. One bit lets interrupt entry drop to full speed. The other lets interrupt return go back to doze. While a debugger is attached, the core runs at full speed and the stored doze bit is left as it is. A sleep request stops either the core only (idle) or both enables (full sleep). A wake input brings both enables back.

There are two active-low asynchronous resets. Power-on/brown-out reset clears the whole register. Any other reset clears everything except the idle-enable bit.

Top module: `cpu_doze_ctrl`

## Requirements
- R1: The register reads back on `busRdata` with bit 7 = idle enable, bit 6 = doze enable, bit 5 = recover-on-interrupt, bit 4 = doze-on-exit, bits 2:0 = ratio code, and bit 3 always 0. A write (`busWe`) takes effect at the next clock edge.
- R2: With doze enabled, ratio code c gives exactly one `cpuEn` cycle in every 2^(c+1) cycles, so code 0 gives 2 and code 7 gives 256.
- R3: With doze enable at 0, `cpuEn` is 1 on every running cycle.
- R4: An `isrEnter` strobe clears doze enable when recover-on-interrupt is 1 and leaves it unchanged when that bit is 0.
- R5: An `isrExit` strobe sets doze enable when doze-on-exit is 1 and leaves it unchanged when that bit is 0.
- R6: While `dbgActive` is 1 and the block is not sleeping, `cpuEn` is 1 in that same cycle, whatever the doze setting.
- R7: `dbgActive` never changes the stored doze enable bit.
- R8: A `sleepReq` with idle enable at 1 gives `cpuEn`=0 and `periphEn`=1 from the next cycle. With idle enable at 0 it gives both enables at 0.
- R9: A change of doze enable or of the ratio code restarts the doze count, so `cpuEn` is 1 in the first cycle after the change.
- R10: `wakeIn` during idle or full sleep restores `periphEn`=1 and the running state on the next cycle.
- R11: A hardware change of doze enable beats a software write to that bit in the same cycle, and interrupt entry beats interrupt return.
- R12: After power-on reset the register reads 0 and both enables are 1. A non-power-on reset clears every bit except idle enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral-rate clock |
| porRstN | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| sysRstN | input | 1 | Other resets, active low, asynchronous; keeps idle enable |
| busWe | input | 1 | Register write strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data |
| isrEnter | input | 1 | Interrupt entry strobe |
| isrExit | input | 1 | Return-from-interrupt strobe |
| dbgActive | input | 1 | Debugger attached; forces full speed |
| sleepReq | input | 1 | Sleep instruction strobe |
| wakeIn | input | 1 | Wake event, ends idle or full sleep |
| cpuEn | output | 1 | Core instruction-cycle enable |
| periphEn | output | 1 | Peripheral clock enable |

## Verification
The bench builds the block with the default 3-bit ratio code, which gives an 8-bit doze counter. With that width even the longest period, 256 cycles for code 7, fits in a few hundred cycles of simulation. The bench therefore checks both ends of the ratio range and one middle code against exact cycle positions. The same build lets the bench restart the count in the middle of a period and confirm that the first enable comes straight after the change.

// File: rtl/doze_pkg.sv
package doze_pkg;

  parameter int DZ_RATIO_W = 3;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_IDLE  = 2'd1,
    PWR_SLEEP = 2'd2
  } pwrState_e;

  // Strobes and levels handed from the control module to the datapath
  typedef struct packed {
    logic                  cntClear;
    logic                  dozeOn;
    logic [DZ_RATIO_W-1:0] ratioCode;
    logic                  running;
    logic                  periphOn;
    logic                  dbgForce;
  } dozeCmd_t;

endpackage

// File: rtl/doze_ctrl.sv
module doze_ctrl
  import doze_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RATIO_W = DZ_RATIO_W
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              isrEnter,
  input  logic              isrExit,
  input  logic              dbgActive,
  input  logic              sleepReq,
  input  logic              wakeIn,
  output dozeCmd_t          cmd
);

  localparam int IDLE_BIT  = DATA_W - 1;
  localparam int DOZE_BIT  = DATA_W - 2;
  localparam int ROI_BIT   = DATA_W - 3;
  localparam int DOE_BIT   = DATA_W - 4;
  localparam int SPARE_BIT = RATIO_W;

  logic               anyRstN;
  logic               idleEnQ;
  logic               dozeEnQ;
  logic               roiQ;
  logic               doeQ;
  logic [RATIO_W-1:0] ratioQ;
  logic               dozeEnNext;
  logic [RATIO_W-1:0] ratioNext;
  pwrState_e          stQ;
  pwrState_e          stNext;
  logic               unusedSpare;

  assign anyRstN     = porRstN & sysRstN;
  assign unusedSpare = busWdata[SPARE_BIT];

  // Doze enable: software write, then return, then entry (highest priority)
  always_comb begin
    dozeEnNext = dozeEnQ;
    if (busWe)              dozeEnNext = busWdata[DOZE_BIT];
    if (isrExit && doeQ)    dozeEnNext = 1'b1;
    if (isrEnter && roiQ)   dozeEnNext = 1'b0;
    ratioNext = busWe ? busWdata[RATIO_W-1:0] : ratioQ;
  end

  // Idle enable survives every reset except power-on
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)   idleEnQ <= 1'b0;
    else if (busWe) idleEnQ <= busWdata[IDLE_BIT];
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      dozeEnQ <= 1'b0;
      roiQ    <= 1'b0;
      doeQ    <= 1'b0;
      ratioQ  <= '0;
    end else begin
      dozeEnQ <= dozeEnNext;
      ratioQ  <= ratioNext;
      if (busWe) begin
        roiQ <= busWdata[ROI_BIT];
        doeQ <= busWdata[DOE_BIT];
      end
    end
  end

  always_comb begin
    stNext = stQ;
    case (stQ)
      PWR_RUN:   if (sleepReq) stNext = idleEnQ ? PWR_IDLE : PWR_SLEEP;
      PWR_IDLE,
      PWR_SLEEP: if (wakeIn)   stNext = PWR_RUN;
      default:                 stNext = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) stQ <= PWR_RUN;
    else          stQ <= stNext;
  end

  always_comb begin
    busRdata           = '0;
    busRdata[IDLE_BIT] = idleEnQ;
    busRdata[DOZE_BIT] = dozeEnQ;
    busRdata[ROI_BIT]  = roiQ;
    busRdata[DOE_BIT]  = doeQ;
    busRdata[RATIO_W-1:0] = ratioQ;
  end

  always_comb begin
    cmd.cntClear  = (dozeEnNext != dozeEnQ) || (ratioNext != ratioQ);
    cmd.dozeOn    = dozeEnQ;
    cmd.ratioCode = ratioQ;
    cmd.running   = (stQ == PWR_RUN);
    cmd.periphOn  = (stQ != PWR_SLEEP);
    cmd.dbgForce  = dbgActive;
  end

endmodule

// File: rtl/doze_datapath.sv
module doze_datapath
  import doze_pkg::*;
#(
  parameter int RATIO_W = DZ_RATIO_W,
  parameter int CNT_W   = 2 ** RATIO_W
) (
  input  logic     clk,
  input  logic     porRstN,
  input  logic     sysRstN,
  input  dozeCmd_t cmd,
  output logic     cpuEn,
  output logic     periphEn
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             anyRstN;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] wrapMask;

  assign anyRstN = porRstN & sysRstN;

  // Period 2^(code+1): mask holds ones in bits 0..code
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      wrapMask[i] = (i <= int'(cmd.ratioCode));
    end
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN)             cntQ <= '0;
    else if (cmd.cntClear)    cntQ <= '0;
    else if (cmd.running) begin
      if (cntQ == wrapMask)   cntQ <= '0;
      else                    cntQ <= cntQ + CNT_ONE;
    end
  end

  assign cpuEn    = cmd.running && (cmd.dbgForce || !cmd.dozeOn || (cntQ == '0));
  assign periphEn = cmd.periphOn;

endmodule

// File: rtl/cpu_doze_ctrl.sv
module cpu_doze_ctrl
  import doze_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RATIO_W = DZ_RATIO_W
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              isrEnter,
  input  logic              isrExit,
  input  logic              dbgActive,
  input  logic              sleepReq,
  input  logic              wakeIn,
  output logic              cpuEn,
  output logic              periphEn
);

  dozeCmd_t cmd;

  doze_ctrl #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .isrEnter(isrEnter), .isrExit(isrExit), .dbgActive(dbgActive),
    .sleepReq(sleepReq), .wakeIn(wakeIn), .cmd(cmd)
  );

  doze_datapath #(.RATIO_W(RATIO_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .cmd(cmd), .cpuEn(cpuEn), .periphEn(periphEn)
  );

endmodule

// File: rtl/doze_checker.sv
module doze_checker (
  input logic       clk,
  input logic       porRstN,
  input logic       sysRstN,
  input logic       busWe,
  input logic [7:0] busRdata,
  input logic       isrEnter,
  input logic       isrExit,
  input logic       dbgActive,
  input logic       sleepReq,
  input logic       wakeIn,
  input logic       cpuEn,
  input logic       periphEn,
  input logic       running
);

  a_r4_entry_clears: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    isrEnter && busRdata[5] |=> !busRdata[6]);

  a_r5_exit_sets: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    isrExit && busRdata[4] && !(isrEnter && busRdata[5]) |=> busRdata[6]);

  a_r11_hw_beats_write: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    busWe && isrEnter && busRdata[5] |=> !busRdata[6]);

  a_r6_debug_full_speed: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    dbgActive && running |-> cpuEn);

  a_r7_debug_keeps_bit: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    dbgActive && !busWe && !isrEnter && !isrExit |=> $stable(busRdata[6]));

  a_r2_gap_after_enable: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    cpuEn && busRdata[6] && !dbgActive && !busWe && !isrEnter && !isrExit
    |=> !cpuEn || dbgActive);

  a_r8_full_sleep_gates_cpu: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    !periphEn |-> !cpuEn);

  a_r8_idle_keeps_periph: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    sleepReq && running && busRdata[7] |=> periphEn && !cpuEn);

  a_r10_wake_restores: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    !running && wakeIn |=> running && periphEn);

endmodule

bind cpu_doze_ctrl doze_checker u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busWe(busWe),
  .busRdata(busRdata), .isrEnter(isrEnter), .isrExit(isrExit),
  .dbgActive(dbgActive), .sleepReq(sleepReq), .wakeIn(wakeIn),
  .cpuEn(cpuEn), .periphEn(periphEn), .running(cmd.running)
);

// File: tb/tb_cpu_doze_ctrl.sv
module tb_cpu_doze_ctrl;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       sysRstN = 1'b0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       isrEnter = 1'b0;
  logic       isrExit = 1'b0;
  logic       dbgActive = 1'b0;
  logic       sleepReq = 1'b0;
  logic       wakeIn = 1'b0;
  logic       cpuEn;
  logic       periphEn;

  always #10 clk = ~clk;

  cpu_doze_ctrl dut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .isrEnter(isrEnter), .isrExit(isrExit), .dbgActive(dbgActive),
    .sleepReq(sleepReq), .wakeIn(wakeIn), .cpuEn(cpuEn), .periphEn(periphEn)
  );

  typedef struct {
    int         cyc;
    bit         useEn;
    logic       cpu;
    logic       per;
    bit         useRd;
    logic [7:0] rd;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   mark = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops items due in this cycle, sampling mid-low-phase
  always begin
    @(negedge clk);
    #5;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        checks++;
        if ((q[i].useEn && (cpuEn !== q[i].cpu || periphEn !== q[i].per)) ||
            (q[i].useRd && busRdata !== q[i].rd)) begin
          errors++;
          $display("FAIL %s cyc %0d cpuEn %b exp %b periphEn %b exp %b rd %h exp %h",
                   q[i].req, cyc, cpuEn, q[i].cpu, periphEn, q[i].per, busRdata, q[i].rd);
        end
        q.delete(i);
      end
    end
  end

  task automatic expEn(int c, logic cpu, logic per, string req);
    exp_t e;
    e.cyc = c; e.useEn = 1'b1; e.cpu = cpu; e.per = per;
    e.useRd = 1'b0; e.rd = 8'h00; e.req = req;
    q.push_back(e);
  endtask

  task automatic expRd(int c, logic [7:0] rd, string req);
    exp_t e;
    e.cyc = c; e.useEn = 1'b0; e.cpu = 1'b0; e.per = 1'b0;
    e.useRd = 1'b1; e.rd = rd; e.req = req;
    q.push_back(e);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // One-cycle stimulus; mark = cycle in which it is presented
  task automatic drive(logic we, logic [7:0] d, logic ent, logic ext, logic slp, logic wk);
    @(negedge clk);
    mark = cyc;
    busWe = we; busWdata = d; isrEnter = ent; isrExit = ext; sleepReq = slp; wakeIn = wk;
    @(negedge clk);
    busWe = 1'b0; isrEnter = 1'b0; isrExit = 1'b0; sleepReq = 1'b0; wakeIn = 1'b0;
  endtask

  initial begin
    waitCyc(3);
    porRstN = 1'b1; sysRstN = 1'b1;
    mark = cyc;
    expEn(mark, 1'b1, 1'b1, "R12_por_enables");
    expRd(mark, 8'h00, "R12_por_register");
    waitCyc(2);

    // R3: doze off, every cycle
    drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= 3; k++) expEn(mark + k, 1'b1, 1'b1, "R3_full_speed");
    waitCyc(4);

    // R2 code 0: period 2; R9 restart on enable
    drive(1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0);
    expRd(mark + 1, 8'h40, "R1_readback");
    expEn(mark + 1, 1'b1, 1'b1, "R9_restart_on_enable");
    expEn(mark + 2, 1'b0, 1'b1, "R2_code0");
    expEn(mark + 3, 1'b1, 1'b1, "R2_code0");
    expEn(mark + 4, 1'b0, 1'b1, "R2_code0");
    waitCyc(5);

    // R2 code 3: period 16
    drive(1'b1, 8'h43, 1'b0, 1'b0, 1'b0, 1'b0);
    expEn(mark + 1, 1'b1, 1'b1, "R9_restart_on_ratio");
    expEn(mark + 2, 1'b0, 1'b1, "R2_code3");
    expEn(mark + 16, 1'b0, 1'b1, "R2_code3");
    expEn(mark + 17, 1'b1, 1'b1, "R2_code3");
    expEn(mark + 33, 1'b1, 1'b1, "R2_code3");
    waitCyc(40);

    // R2 code 7: period 256
    drive(1'b1, 8'h47, 1'b0, 1'b0, 1'b0, 1'b0);
    expEn(mark + 1, 1'b1, 1'b1, "R9_restart_on_ratio");
    expEn(mark + 128, 1'b0, 1'b1, "R2_code7");
    expEn(mark + 256, 1'b0, 1'b1, "R2_code7");
    expEn(mark + 257, 1'b1, 1'b1, "R2_code7");
    waitCyc(260);

    // R1: bit 3 reads 0
    drive(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    expRd(mark + 1, 8'hF7, "R1_spare_bit");
    waitCyc(2);

    // R4: entry clears doze enable
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expRd(mark + 1, 8'hB7, "R4_entry_clears");
    expEn(mark + 1, 1'b1, 1'b1, "R4_full_speed");
    expEn(mark + 2, 1'b1, 1'b1, "R4_full_speed");
    waitCyc(3);

    // R5: return sets doze enable
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    expRd(mark + 1, 8'hF7, "R5_exit_sets");
    expEn(mark + 1, 1'b1, 1'b1, "R9_restart_on_exit");
    expEn(mark + 2, 1'b0, 1'b1, "R5_dozing");
    waitCyc(3);

    // R4/R5 policy bits at 0
    drive(1'b1, 8'h47, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    expRd(mark + 1, 8'h47, "R4_entry_no_effect");
    waitCyc(2);
    drive(1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    expRd(mark + 1, 8'h07, "R5_exit_no_effect");
    expEn(mark + 1, 1'b1, 1'b1, "R3_doze_off");
    expEn(mark + 2, 1'b1, 1'b1, "R3_doze_off");
    waitCyc(3);

    // R11: priorities
    drive(1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h70, 1'b1, 1'b0, 1'b0, 1'b0);
    expRd(mark + 1, 8'h30, "R11_entry_over_write");
    waitCyc(2);
    drive(1'b1, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0);
    expRd(mark + 1, 8'h70, "R11_exit_over_write");
    waitCyc(2);
    drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    expRd(mark + 1, 8'h30, "R11_entry_over_exit");
    waitCyc(2);

    // R6/R7: debug override
    drive(1'b1, 8'h47, 1'b0, 1'b0, 1'b0, 1'b0);
    waitCyc(3);
    dbgActive = 1'b1;
    mark = cyc;
    for (int k = 0; k <= 3; k++) begin
      expEn(mark + k, 1'b1, 1'b1, "R6_debug_full_speed");
      expRd(mark + k, 8'h47, "R7_debug_bit_kept");
    end
    waitCyc(4);
    dbgActive = 1'b0;
    mark = cyc;
    expRd(mark, 8'h47, "R7_after_debug");
    waitCyc(2);

    // R8/R10: idle
    drive(1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expEn(mark + 1, 1'b0, 1'b1, "R8_idle");
    expEn(mark + 3, 1'b0, 1'b1, "R8_idle");
    waitCyc(3);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    expEn(mark + 1, 1'b1, 1'b1, "R10_wake_idle");
    waitCyc(2);

    // R8/R10: full sleep
    drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expEn(mark + 1, 1'b0, 1'b0, "R8_full_sleep");
    expEn(mark + 2, 1'b0, 1'b0, "R8_full_sleep");
    waitCyc(2);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    expEn(mark + 1, 1'b1, 1'b1, "R10_wake_sleep");
    waitCyc(2);

    // R12: warm reset keeps idle enable, power-on clears it
    drive(1'b1, 8'hB5, 1'b0, 1'b0, 1'b0, 1'b0);
    expRd(mark + 1, 8'hB5, "R1_readback");
    waitCyc(1);
    sysRstN = 1'b0;
    waitCyc(2);
    sysRstN = 1'b1;
    mark = cyc;
    expRd(mark, 8'h80, "R12_warm_reset");
    expEn(mark, 1'b1, 1'b1, "R12_warm_enables");
    waitCyc(2);
    porRstN = 1'b0;
    waitCyc(2);
    porRstN = 1'b1;
    mark = cyc;
    expRd(mark, 8'h00, "R12_por_clears_idle");
    waitCyc(3);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 pending %0d expected items unchecked, expected 0", q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule